// File: doc/BRIEF.md
# Serial NRZ Receive Interface Toward a MAC

This block sits between a 10 Mb/s transceiver's decoder and a set of MAC serial ports, one slice per port. Each slice takes a decoded bit stream with a valid flag, a collision-detect flag and the MAC's transmit enable. Toward the MAC it presents receive data, a receive clock, carrier sense and collision. All slices share one bit timer. The core clock runs at twice the bit rate, so each bit period is two core clocks: a boundary clock and a high-phase clock. The bit timer also drives the shared transmit clock.

A small state machine in each slice decides whether the receive clock runs. Its states are STOPPED, CARRIER, TAIL and FREE. The transitions are:
- carrier seen: STOPPED, TAIL or FREE goes to CARRIER.
- carrier lost in five-cycle mode: CARRIER goes to TAIL.
- carrier lost in continuous mode: CARRIER goes to FREE.
- tail done: TAIL goes to STOPPED after the last counted period.
- mode to continuous: STOPPED or TAIL goes to FREE.
- mode to five-cycle: FREE goes to STOPPED.

A second state machine per slice, with states IDLE, TX and PULSE, produces the SQE-test pulse after each transmitted packet. Its transitions are:
- tx start: IDLE goes to TX.
- tx end: TX goes to PULSE.
- pulse done: PULSE goes to IDLE, or to TX if transmit enable is already high again.

The gating mode is a single bit shared by all slices: 1 means five-cycle stop, 0 means continuous. The bit is loaded from a strap input while reset is held and may be rewritten at any time afterwards.

Top module: `nrz_mac_rx_if`

## Requirements
- R1: `txc_o` is low during reset and toggles on every core clock after reset is released. It rises on the first clock edge after release.
- R2: At each bit boundary, `crs_o` takes the value of `dec_valid_i` and `rxd_o` takes `dec_valid_i & dec_data_i`. Bit boundaries are the 2nd, 4th, 6th... clock edges after reset release. `rxc_o` rises one core clock after the boundary, so the data is stable at every rising edge of `rxc_o`.
- R3: While carrier is present, `rxc_o` gives exactly one rising edge per bit period.
- R4: With mode bit 1, `rxc_o` gives exactly 5 rising edges after the boundary where carrier drops, then stays low. `rxd_o` and `crs_o` stay 0 while the clock is stopped.
- R5: With mode bit 0, `rxc_o` gives one rising edge per bit period even with no carrier.
- R6: On a new carrier, the clock restarts with its rising edge one core clock after the boundary. Every high phase of `rxc_o` lasts exactly one core clock. A carrier that returns during the tail keeps the clock running.
- R7: While `rst` is high, `gate_strap_i` is loaded into the mode bit. 1 selects five-cycle mode and 0 selects continuous mode.
- R8: When `cfg_we_i` is high on a clock edge after reset, the mode bit takes `cfg_gate_i`. The new mode acts from the next bit boundary and holds until the next reset.
- R9: The live collision flag is sampled at each bit boundary and drives `col_o`.
- R10: At the boundary where transmit enable is first seen low after being high, `col_o` asserts. It stays high for exactly 10 bit periods.
- R11: `col_o` is the OR of the live collision and the SQE pulse, so an overlapping collision extends it.
- R12: Reset clears `rxc_o`, `rxd_o`, `crs_o` and `col_o` to 0.
- R13: Each port slice responds only to its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| gate_strap_i | input | 1 | Reset-time mode strap (1 = five-cycle stop) |
| cfg_we_i | input | 1 | Mode bit write strobe |
| cfg_gate_i | input | 1 | Mode bit write value |
| dec_data_i | input | NUM_PORTS | Decoded receive bit per port |
| dec_valid_i | input | NUM_PORTS | Decoded data valid (carrier) per port |
| col_det_i | input | NUM_PORTS | Live collision detect per port |
| tx_en_i | input | NUM_PORTS | MAC transmit enable per port |
| txc_o | output | 1 | Shared transmit clock |
| rxc_o | output | NUM_PORTS | Gated receive clock per port |
| rxd_o | output | NUM_PORTS | Receive data per port |
| crs_o | output | NUM_PORTS | Carrier sense per port |
| col_o | output | NUM_PORTS | Collision / SQE test per port |

## Verification
A gating state machine stuck in STOPPED shows up within one bit period of a new carrier as a missing `rxc_o` edge. One that never leaves TAIL shows up five bit periods after carrier drops, because extra edges appear. An off-by-one in the tail or SQE counter changes the edge count or the `col_o` length by exactly one bit period, and the bench counts both exactly. A mode bit that ignores the strap or the write is visible at the next idle bit boundary, where the clock either runs or stays low.

// File: rtl/nrz_mac_rx_pkg.sv
package nrz_mac_rx_pkg;

    // Receive clock gating states
    typedef enum logic [1:0] {
        RG_STOPPED = 2'd0,
        RG_CARRIER = 2'd1,
        RG_TAIL    = 2'd2,
        RG_FREE    = 2'd3
    } rxg_state_e;

    // SQE test generator states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_TX    = 2'd1,
        SQ_PULSE = 2'd2
    } sqe_state_e;

    // Mode bit encoding
    localparam logic GATE_FIVE = 1'b1;
    localparam logic GATE_CONT = 1'b0;

endpackage

// File: rtl/nrz_bit_timer.sv
module nrz_bit_timer (
    input  logic clk,
    input  logic rst,
    output logic bnd_o,
    output logic txc_o
);

    logic ph_q;

    // Phase toggles every core clock; phase 1 marks the next edge as a boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    assign bnd_o = ph_q;
    assign txc_o = ph_q;

    // R1
    txc_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (txc_o != $past(txc_o)));

endmodule

// File: rtl/nrz_gate_cfg.sv
module nrz_gate_cfg (
    input  logic clk,
    input  logic rst,
    input  logic strap_i,
    input  logic we_i,
    input  logic gate_i,
    output logic gate_five_o
);

    logic mode_q;

    // Strap captured throughout reset; runtime write overrides afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= strap_i;
        end else if (we_i) begin
            mode_q <= gate_i;
        end
    end

    assign gate_five_o = mode_q;

    // R7
    strap_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gate_five_o == $past(strap_i)));

    // R8
    write_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we_i)) |-> (gate_five_o == $past(gate_i)));

    // R8
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we_i)) |-> $stable(gate_five_o));

endmodule

// File: rtl/nrz_rx_gate_fsm.sv
module nrz_rx_gate_fsm
    import nrz_mac_rx_pkg::*;
#(
    parameter int TAIL_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bnd_i,
    input  logic gate_five_i,
    input  logic dval_i,
    input  logic din_i,
    output logic rxc_o,
    output logic rxd_o,
    output logic crs_o
);

    localparam int             CW        = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1;
    localparam logic [CW-1:0]  TAIL_LAST = CW'(TAIL_CYCLES - 1);

    rxg_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          run_q;
    logic          rxc_q, rxd_q, crs_q;

    // State register: advances only at bit boundaries
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RG_STOPPED;
            cnt_q   <= '0;
        end else if (bnd_i) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RG_STOPPED: begin
                if (dval_i) begin
                    state_d = RG_CARRIER;
                end else if (gate_five_i == GATE_CONT) begin
                    state_d = RG_FREE;
                end
            end
            RG_CARRIER: begin
                if (!dval_i) begin
                    if (gate_five_i == GATE_FIVE) begin
                        state_d = RG_TAIL;
                        cnt_d   = '0;
                    end else begin
                        state_d = RG_FREE;
                    end
                end
            end
            RG_TAIL: begin
                if (dval_i) begin
                    state_d = RG_CARRIER;
                end else if (gate_five_i == GATE_CONT) begin
                    state_d = RG_FREE;
                end else if (cnt_q == TAIL_LAST) begin
                    state_d = RG_STOPPED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RG_FREE: begin
                if (dval_i) begin
                    state_d = RG_CARRIER;
                end else if (gate_five_i == GATE_FIVE) begin
                    state_d = RG_STOPPED;
                end
            end
            default: begin
                state_d = RG_STOPPED;
            end
        endcase
    end

    // Outputs: data and carrier at boundary, clock high in the following slot
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            rxc_q <= 1'b0;
            rxd_q <= 1'b0;
            crs_q <= 1'b0;
        end else if (bnd_i) begin
            run_q <= (state_d != RG_STOPPED);
            crs_q <= dval_i;
            rxd_q <= dval_i & din_i;
            rxc_q <= 1'b0;
        end else begin
            rxc_q <= run_q;
        end
    end

    assign rxc_o = rxc_q;
    assign rxd_o = rxd_q;
    assign crs_o = crs_q;

    // R6
    rxc_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        rxc_q |=> !rxc_q);

    // R4
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RG_STOPPED) |-> (!rxc_q && !rxd_q && !crs_q));

    // R3
    crs_run_chk: assert property (@(posedge clk) disable iff (rst)
        crs_q |-> run_q);

    // R4
    tail_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RG_TAIL) |-> (cnt_q <= TAIL_LAST));

endmodule

// File: rtl/nrz_sqe_fsm.sv
module nrz_sqe_fsm
    import nrz_mac_rx_pkg::*;
#(
    parameter int SQE_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic bnd_i,
    input  logic tx_en_i,
    input  logic col_det_i,
    output logic col_o
);

    localparam int            SW       = $clog2(SQE_CYCLES + 1);
    localparam logic [SW-1:0] SQE_LAST = SW'(SQE_CYCLES);

    sqe_state_e    state_q, state_d;
    logic [SW-1:0] cnt_q, cnt_d;
    logic          sqe_q, col_live_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else if (bnd_i) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (tx_en_i) begin
                    state_d = SQ_TX;
                end
            end
            SQ_TX: begin
                if (!tx_en_i) begin
                    state_d = SQ_PULSE;
                    cnt_d   = SW'(1);
                end
            end
            SQ_PULSE: begin
                if (cnt_q == SQE_LAST) begin
                    state_d = tx_en_i ? SQ_TX : SQ_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = SQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sqe_q      <= 1'b0;
            col_live_q <= 1'b0;
        end else if (bnd_i) begin
            sqe_q      <= (state_d == SQ_PULSE);
            col_live_q <= col_det_i;
        end
    end

    assign col_o = col_live_q | sqe_q;

    // R10
    sqe_from_tx_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sqe_q) |-> ($past(state_q) == SQ_TX));

    // R10
    sqe_len_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= SQE_LAST);

    // R9
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bnd_i)) |-> $stable(col_live_q));

endmodule

// File: rtl/nrz_mac_rx_if.sv
module nrz_mac_rx_if
    import nrz_mac_rx_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int TAIL_CYCLES = 5,
    parameter int SQE_CYCLES  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gate_strap_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_gate_i,
    input  logic [NUM_PORTS-1:0] dec_data_i,
    input  logic [NUM_PORTS-1:0] dec_valid_i,
    input  logic [NUM_PORTS-1:0] col_det_i,
    input  logic [NUM_PORTS-1:0] tx_en_i,
    output logic                 txc_o,
    output logic [NUM_PORTS-1:0] rxc_o,
    output logic [NUM_PORTS-1:0] rxd_o,
    output logic [NUM_PORTS-1:0] crs_o,
    output logic [NUM_PORTS-1:0] col_o
);

    logic bnd;
    logic gate_five;

    nrz_bit_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .bnd_o (bnd),
        .txc_o (txc_o)
    );

    nrz_gate_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .strap_i     (gate_strap_i),
        .we_i        (cfg_we_i),
        .gate_i      (cfg_gate_i),
        .gate_five_o (gate_five)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        nrz_rx_gate_fsm #(
            .TAIL_CYCLES (TAIL_CYCLES)
        ) u_rx (
            .clk         (clk),
            .rst         (rst),
            .bnd_i       (bnd),
            .gate_five_i (gate_five),
            .dval_i      (dec_valid_i[p]),
            .din_i       (dec_data_i[p]),
            .rxc_o       (rxc_o[p]),
            .rxd_o       (rxd_o[p]),
            .crs_o       (crs_o[p])
        );

        nrz_sqe_fsm #(
            .SQE_CYCLES (SQE_CYCLES)
        ) u_sqe (
            .clk       (clk),
            .rst       (rst),
            .bnd_i     (bnd),
            .tx_en_i   (tx_en_i[p]),
            .col_det_i (col_det_i[p]),
            .col_o     (col_o[p])
        );

        // R2
        rxd_needs_crs_chk: assert property (@(posedge clk) disable iff (rst)
            rxd_o[p] |-> crs_o[p]);
    end

endmodule

// File: tb/nrz_mac_rx_if_bench.sv
module nrz_mac_rx_if_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap = 1'b1;
    logic       we = 1'b0;
    logic       cgate = 1'b0;
    logic [3:0] din = '0, dval = '0, cdet = '0, txen = '0;
    logic       txc;
    logic [3:0] rxc, rxd, crs, col;

    int n_chk = 0;
    int n_fail = 0;
    int edges0 = 0, edges1 = 0, edges2 = 0;
    logic [7:0] cap0 = '0;

    always #2 clk = ~clk;

    nrz_mac_rx_if u_nrz_mac_rx_if (
        .clk          (clk),
        .rst          (rst),
        .gate_strap_i (strap),
        .cfg_we_i     (we),
        .cfg_gate_i   (cgate),
        .dec_data_i   (din),
        .dec_valid_i  (dval),
        .col_det_i    (cdet),
        .tx_en_i      (txen),
        .txc_o        (txc),
        .rxc_o        (rxc),
        .rxd_o        (rxd),
        .crs_o        (crs),
        .col_o        (col)
    );

    always @(posedge rxc[0]) begin
        edges0 = edges0 + 1;
        cap0   = {cap0[6:0], rxd[0]};
    end
    always @(posedge rxc[1]) edges1 = edges1 + 1;
    always @(posedge rxc[2]) edges2 = edges2 + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One bit period: two core clocks, returns just after the boundary edge
    task automatic step();
        @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic s);
        rst   = 1'b1;
        strap = s;
        din = '0; dval = '0; cdet = '0; txen = '0;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // R12, R1, R7, R4
    task automatic t_reset();
        int b0, b2;
        do_reset(1'b1);
        chk("R12 rxc", int'(rxc), 0);
        chk("R12 rxd", int'(rxd), 0);
        chk("R12 crs", int'(crs), 0);
        chk("R12 col", int'(col), 0);
        chk("R1 txc low", int'(txc), 0);
        @(posedge clk); #1;
        chk("R1 txc rise", int'(txc), 1);
        @(posedge clk); #1;
        chk("R1 txc fall", int'(txc), 0);
        b0 = edges0; b2 = edges2;
        repeat (4) step();
        chk("R7 strap five idle port0", edges0 - b0, 0);
        chk("R7 strap five idle port2", edges2 - b2, 0);
    endtask

    // R2, R3, R13, R4
    task automatic t_frame();
        logic [7:0] pat = 8'hB4;
        int b0, b1;
        b0 = edges0; b1 = edges1;
        for (int i = 0; i < 8; i++) begin
            din[0]  = pat[7-i];
            dval[0] = 1'b1;
            step();
            chk("R2 crs", int'(crs[0]), 1);
            chk("R2 rxd", int'(rxd[0]), int'(pat[7-i]));
        end
        din[0] = 1'b0; dval[0] = 1'b0;
        step();
        chk("R3 edges during carrier", edges0 - b0, 8);
        chk("R2 data at rising edges", int'(cap0), int'(pat));
        chk("R2 crs drop", int'(crs[0]), 0);
        chk("R13 port1 no clock", edges1 - b1, 0);
        chk("R13 port1 no carrier", int'(crs[1]), 0);
        b0 = edges0;
        repeat (8) step();
        chk("R4 tail edges", edges0 - b0, 5);
        chk("R4 rxd quiet", int'(rxd[0]), 0);
        @(posedge clk); #1;
        chk("R4 rxc held low", int'(rxc[0]), 0);
        @(posedge clk); #1;
    endtask

    // R6
    task automatic t_restart();
        int b0;
        b0 = edges0;
        dval[0] = 1'b1; din[0] = 1'b1;
        step();
        chk("R6 low at boundary", int'(rxc[0]), 0);
        @(posedge clk); #1;
        chk("R6 rise one clk later", int'(rxc[0]), 1);
        @(posedge clk); #1;
        chk("R6 one clk high", int'(rxc[0]), 0);
        step();
        dval[0] = 1'b0; din[0] = 1'b0;
        step(); step();
        chk("R6 crs low in tail", int'(crs[0]), 0);
        dval[0] = 1'b1;
        step();
        chk("R6 crs back", int'(crs[0]), 1);
        step();
        dval[0] = 1'b0;
        repeat (8) step();
        chk("R6 retriggered tail edges", edges0 - b0, 12);
    endtask

    // R10, R13
    task automatic t_sqe();
        txen[1] = 1'b1;
        repeat (4) step();
        chk("R10 no col during tx", int'(col[1]), 0);
        txen[1] = 1'b0;
        for (int k = 1; k <= 11; k++) begin
            step();
            chk("R10 sqe window", int'(col[1]), (k <= 10) ? 1 : 0);
            chk("R13 port0 col quiet", int'(col[0]), 0);
        end
    endtask

    // R9, R11
    task automatic t_col();
        cdet[0] = 1'b1;
        repeat (3) begin
            step();
            chk("R9 live col", int'(col[0]), 1);
        end
        cdet[0] = 1'b0;
        step();
        chk("R9 live col drop", int'(col[0]), 0);
        txen[1] = 1'b1;
        repeat (2) step();
        txen[1] = 1'b0;
        for (int k = 1; k <= 14; k++) begin
            cdet[1] = (k >= 9 && k <= 12);
            step();
            chk("R11 col or sqe", int'(col[1]), (k <= 12) ? 1 : 0);
        end
        cdet[1] = 1'b0;
    endtask

    // R8, R5
    task automatic t_write();
        int b0, b2;
        we = 1'b1; cgate = 1'b0;
        step();
        we = 1'b0;
        b0 = edges0; b2 = edges2;
        repeat (6) step();
        chk("R5 free clock port0", edges0 - b0, 6);
        chk("R5 free clock port2", edges2 - b2, 6);
        chk("R5 no carrier", int'(crs[0]), 0);
        we = 1'b1; cgate = 1'b1;
        step();
        we = 1'b0;
        b0 = edges0;
        repeat (4) step();
        chk("R8 write five stops clock", edges0 - b0, 0);
    endtask

    // R7, R8
    task automatic t_strap0();
        int b0;
        do_reset(1'b0);
        step();
        b0 = edges0;
        repeat (5) step();
        chk("R7 strap cont after reset", edges0 - b0, 5);
    endtask

    initial begin
        t_reset();
        t_frame();
        t_restart();
        t_sqe();
        t_col();
        t_write();
        t_strap0();
        report();
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

endmodule